// File: doc/BRIEF.md
# External Memory Bus Controller

This block connects a simple internal request port to an external asynchronous memory bus. An internal master presents an address, write data, a two-bit byte-lane enable and a read/write flag under a valid/ready handshake. The controller then runs one external bus cycle for that request. A read returns its data on a one-cycle response pulse. A write also gets a response pulse, which marks the end of its bus cycle.

The external side can run with separate address and data lines or with multiplexed lines, where the low data lines carry the address while the latch enable is high. The data width is 16 or 8 bits, chosen by a static input. Four active-low chip selects decode the top address bits. Writes use one of two strobe styles, selected at run time: either a pair of per-byte write strobes, or one write strobe together with a high-byte enable. An external device can take the bus through a hold request, which is granted only between bus cycles. A ready input stretches the strobe phase with wait states.

Top module: `ext_bus_ctrl`

## Requirements
- R1: When `cfg_bus8` is 0 the bus is 16 bits wide: a read returns all of `ext_d_in`, and a write drives all of `req_wdata`. When `cfg_bus8` is 1 the bus is 8 bits wide: a read returns `{8'h00, ext_d_in[7:0]}`, and a write drives `{8'h00, req_wdata[7:0]}`. Write data is driven with `ext_d_oe` high from the strobe cycle onward.
- R2: `ext_addr` carries 20 bits. With the 8-bit bus it is the byte address `req_addr`. With the 16-bit bus it is `{req_addr[19:1], a0}`, where a0 is 1 only when `req_be` is 2'b10.
- R3: In multiplexed mode (`cfg_mux`=1) on the 8-bit bus, the cycle with `ext_ale` high drives `req_addr[7:0]` on `ext_d_out[7:0]` with `ext_d_oe` high. In separate mode `ext_d_oe` is low in that cycle.
- R4: In multiplexed mode on the 16-bit bus, the cycle with `ext_ale` high drives `req_addr[8:1]` on `ext_d_out[7:0]`.
- R5: `ext_cs_n[i]` is low exactly when `req_addr[19:18]` equals i. It holds from the latch-enable cycle through the release cycle. At most one chip select is low at any time.
- R6: Split style (`cfg_wr_combined`=0 with the 16-bit bus): on a write, `ext_wrl_n` goes low when `req_be[0]` is set (even byte) and `ext_wrh_n` goes low when `req_be[1]` is set (odd byte).
- R7: Combined style (`cfg_wr_combined`=1, or any time `cfg_bus8`=1): `ext_wrl_n` is a single write strobe that goes low on every write. `ext_wrh_n` is a high-byte enable that stays low from the latch-enable cycle through the release cycle of any access to the odd byte (`req_be[1]` on the 16-bit bus, `req_addr[0]` on the 8-bit bus).
- R8: `ext_rd_n` goes low in the strobe phase of every read. It never goes low together with the write strobe on `ext_wrl_n`.
- R9: A request accepted at clock edge k raises `ext_ale` for exactly the cycle after edge k. The strobes go low after edge k+1. The latch enable and any strobe are never active in the same cycle.
- R10: `ext_ready` is sampled at each edge of the strobe phase. The strobe stays low while the sample is 0 and rises after the first edge that samples 1, so the strobe lasts 1 + (number of low samples) cycles. `resp_valid` is high for that one following cycle.
- R11: A low `ext_hold_n` passes two synchronizer flops. If the block is idle, `ext_hlda_n` goes low at the third edge after the input falls. While held, `ext_bus_oe`, `ext_d_oe` and `req_ready` are 0 and no bus cycle starts. When `ext_hold_n` returns high, the hold ends and a stalled request proceeds.
- R12: Hold is never granted during a bus cycle. A hold request that arrives mid-cycle is granted only after the cycle's release.
- R13: After reset, all chip selects and strobes are high, `ext_ale` and `resp_valid` are 0, `ext_hlda_n` is 1, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus8 | input | 1 | External data width: 0 = 16 bits, 1 = 8 bits |
| cfg_mux | input | 1 | 1 = address multiplexed onto low data lines |
| cfg_wr_combined | input | 1 | 1 = single write strobe plus high-byte enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lanes (bit 0 even, bit 1 odd), 16-bit bus only |
| req_we | input | 1 | 1 = write, 0 = read |
| resp_valid | output | 1 | One-cycle end-of-cycle pulse |
| resp_rdata | output | 16 | Read data |
| ext_addr | output | 20 | External address |
| ext_d_out | output | 16 | Data/address driven onto the shared lines |
| ext_d_in | input | 16 | Data read from the shared lines |
| ext_d_oe | output | 1 | Data line output enable |
| ext_bus_oe | output | 1 | Output enable for address, chip selects and strobes |
| ext_cs_n | output | 4 | Active-low chip selects |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wrl_n | output | 1 | Low-byte write strobe or single write strobe |
| ext_wrh_n | output | 1 | High-byte write strobe or high-byte enable |
| ext_ready | input | 1 | 0 inserts wait states |
| ext_hold_n | input | 1 | Active-low bus hold request |
| ext_hlda_n | output | 1 | Active-low hold acknowledge |

## Verification
Take the edge that accepts a request as edge k. The latch-enable cycle, with its address, chip select and multiplexed address, follows edge k. The first strobe cycle follows edge k+1. The response pulse falls in the cycle after the first edge that samples ready high, and it coincides with the release cycle, so chip selects are compared there too. The bench samples all of these at falling edges: it records the address-phase values when it sees the latch enable, counts strobe cycles, and compares both sets against the queued expectation when the response pulse appears. Hold acknowledge is checked three edges after the hold input falls while idle. During a bus cycle it is checked to stay high until the release.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int unsigned EBC_ADDR_W = 20;
  localparam int unsigned EBC_DATA_W = 16;
  localparam int unsigned EBC_NUM_CS = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_STRB = 3'd2,
    ST_REL  = 3'd3,
    ST_HOLD = 3'd4
  } ebc_state_e;

  typedef struct packed {
    logic lo;
    logic hi;
  } ebc_lane_t;
endpackage

// File: rtl/ebc_sync.sv
module ebc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ebc_cs_decode.sv
module ebc_cs_decode #(
  parameter  int NUM_CS = 4,
  localparam int SEL_W  = $clog2(NUM_CS)
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = (sel != SEL_W'(i));
  end
endmodule

// File: rtl/ebc_lane_map.sv
module ebc_lane_map
  import ebc_pkg::*;
#(
  parameter  int ADDR_W = 20,
  parameter  int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bus8,
  output logic [ADDR_W-1:0] xaddr,
  output ebc_lane_t         lane,
  output logic [DATA_W-1:0] aphase,
  output logic [DATA_W-1:0] wbus
);
  always_comb begin
    if (bus8) begin
      lane.lo = ~addr[0];
      lane.hi = addr[0];
      xaddr   = addr;
      aphase  = {{HALF_W{1'b0}}, addr[HALF_W-1:0]};
      wbus    = {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
    end else begin
      lane.lo = be[0];
      lane.hi = be[1];
      xaddr   = {addr[ADDR_W-1:1], ~be[0] & be[1]};
      aphase  = {{HALF_W{1'b0}}, addr[HALF_W:1]};
      wbus    = wdata;
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W    = EBC_ADDR_W,
  parameter int DATA_W    = EBC_DATA_W,
  parameter int NUM_CS    = EBC_NUM_CS,
  parameter int HOLD_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bus8,
  input  logic              cfg_mux,
  input  logic              cfg_wr_combined,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  input  logic              req_we,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_d_out,
  input  logic [DATA_W-1:0] ext_d_in,
  output logic              ext_d_oe,
  output logic              ext_bus_oe,
  output logic [NUM_CS-1:0] ext_cs_n,
  output logic              ext_ale,
  output logic              ext_rd_n,
  output logic              ext_wrl_n,
  output logic              ext_wrh_n,
  input  logic              ext_ready,
  input  logic              ext_hold_n,
  output logic              ext_hlda_n
);
  localparam int SEL_W  = $clog2(NUM_CS);
  localparam int HALF_W = DATA_W / 2;

  ebc_state_e        state;
  logic              hold_n_s;
  logic              hold_req;
  logic              comb_eff;
  logic [NUM_CS-1:0] cs_dec_n;
  logic [ADDR_W-1:0] map_xaddr;
  ebc_lane_t         map_lane;
  logic [DATA_W-1:0] map_aphase;
  logic [DATA_W-1:0] map_wbus;

  logic              we_q;
  logic              comb_q;
  logic              bus8_q;
  ebc_lane_t         lane_q;
  logic [DATA_W-1:0] wbus_q;

  ebc_sync #(.STAGES(HOLD_SYNC), .RST_VAL(1'b1)) u_hold_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_hold_n),
    .q   (hold_n_s)
  );

  ebc_cs_decode #(.NUM_CS(NUM_CS)) u_cs_dec (
    .sel  (req_addr[ADDR_W-1 -: SEL_W]),
    .cs_n (cs_dec_n)
  );

  ebc_lane_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
    .addr   (req_addr),
    .be     (req_be),
    .wdata  (req_wdata),
    .bus8   (cfg_bus8),
    .xaddr  (map_xaddr),
    .lane   (map_lane),
    .aphase (map_aphase),
    .wbus   (map_wbus)
  );

  assign hold_req  = ~hold_n_s;
  assign comb_eff  = cfg_bus8 | cfg_wr_combined;
  assign req_ready = (state == ST_IDLE) && !hold_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ext_ale    <= 1'b0;
      ext_cs_n   <= '1;
      ext_rd_n   <= 1'b1;
      ext_wrl_n  <= 1'b1;
      ext_wrh_n  <= 1'b1;
      ext_addr   <= '0;
      ext_d_out  <= '0;
      ext_d_oe   <= 1'b0;
      ext_bus_oe <= 1'b1;
      ext_hlda_n <= 1'b1;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      we_q       <= 1'b0;
      comb_q     <= 1'b0;
      bus8_q     <= 1'b0;
      lane_q     <= '0;
      wbus_q     <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (hold_req) begin
            state      <= ST_HOLD;
            ext_hlda_n <= 1'b0;
            ext_bus_oe <= 1'b0;
            ext_d_oe   <= 1'b0;
          end else if (req_valid) begin
            state     <= ST_ADDR;
            ext_ale   <= 1'b1;
            ext_cs_n  <= cs_dec_n;
            ext_addr  <= map_xaddr;
            ext_wrh_n <= ~(comb_eff & map_lane.hi);
            ext_d_out <= map_aphase;
            ext_d_oe  <= cfg_mux;
            we_q      <= req_we;
            comb_q    <= comb_eff;
            bus8_q    <= cfg_bus8;
            lane_q    <= map_lane;
            wbus_q    <= map_wbus;
          end
        end
        ST_ADDR: begin
          state     <= ST_STRB;
          ext_ale   <= 1'b0;
          ext_rd_n  <= we_q;
          ext_wrl_n <= ~(we_q & (comb_q | lane_q.lo));
          if (!comb_q) ext_wrh_n <= ~(we_q & lane_q.hi);
          ext_d_out <= wbus_q;
          ext_d_oe  <= we_q;
        end
        ST_STRB: begin
          if (ext_ready) begin
            state      <= ST_REL;
            ext_rd_n   <= 1'b1;
            ext_wrl_n  <= 1'b1;
            if (!comb_q) ext_wrh_n <= 1'b1;
            resp_valid <= 1'b1;
            resp_rdata <= bus8_q ? {{HALF_W{1'b0}}, ext_d_in[HALF_W-1:0]} : ext_d_in;
          end
        end
        ST_REL: begin
          state     <= ST_IDLE;
          ext_cs_n  <= '1;
          ext_wrh_n <= 1'b1;
          ext_d_oe  <= 1'b0;
        end
        ST_HOLD: begin
          if (!hold_req) begin
            state      <= ST_IDLE;
            ext_hlda_n <= 1'b1;
            ext_bus_oe <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ext_cs_n));

  assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !ext_rd_n |-> ext_wrl_n);

  assert_ale_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    ext_ale |-> (ext_rd_n && ext_wrl_n));

  assert_ale_single_R9: assert property (@(posedge clk) disable iff (rst)
    ext_ale |=> !ext_ale);

  assert_rd_wait_R10: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n && !ext_ready) |=> !ext_rd_n);

  assert_wr_wait_R10: assert property (@(posedge clk) disable iff (rst)
    (!ext_wrl_n && !ext_ready) |=> !ext_wrl_n);

  assert_rd_release_R10: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n && ext_ready) |=> (ext_rd_n && resp_valid));

  assert_hold_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !ext_hlda_n |-> (!ext_bus_oe && !ext_d_oe && !req_ready));

  assert_no_hold_midcycle_R12: assert property (@(posedge clk) disable iff (rst)
    !(&ext_cs_n) |-> ext_hlda_n);
endmodule

// File: tb/sim_ext_bus_ctrl.sv
module sim_ext_bus_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic        mux;
    logic        bus8;
    logic        comb;
    logic [19:0] xaddr;
    logic [3:0]  cs_n;
    logic [7:0]  aphase;
    logic        bhe_a;
    logic        rd_n;
    logic        wrl_n;
    logic        wrh_n;
    logic [15:0] wbus;
    logic [15:0] rdata;
    logic [7:0]  slen;
  } exp_t;

  logic clk, rst;
  logic cfg_bus8, cfg_mux, cfg_wr_combined;
  logic req_valid, req_ready, req_we;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic resp_valid;
  logic [15:0] resp_rdata;
  logic [19:0] ext_addr;
  logic [15:0] ext_d_out, ext_d_in;
  logic ext_d_oe, ext_bus_oe, ext_ale, ext_rd_n, ext_wrl_n, ext_wrh_n;
  logic [3:0] ext_cs_n;
  logic ext_ready, ext_hold_n, ext_hlda_n;

  int n_cmp = 0;
  int n_bad = 0;
  int wait_cfg = 0;
  int wcnt = 0;
  int n_ale = 0;
  exp_t expq[$];

  ext_bus_ctrl u0 (
    .clk(clk), .rst(rst),
    .cfg_bus8(cfg_bus8), .cfg_mux(cfg_mux), .cfg_wr_combined(cfg_wr_combined),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_we(req_we),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .ext_addr(ext_addr), .ext_d_out(ext_d_out), .ext_d_in(ext_d_in),
    .ext_d_oe(ext_d_oe), .ext_bus_oe(ext_bus_oe), .ext_cs_n(ext_cs_n),
    .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wrl_n(ext_wrl_n),
    .ext_wrh_n(ext_wrh_n), .ext_ready(ext_ready), .ext_hold_n(ext_hold_n),
    .ext_hlda_n(ext_hlda_n)
  );

  assign ext_d_in = ext_addr[15:0] ^ 16'h5A3C;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic strobing();
    logic split;
    split = !cfg_bus8 && !cfg_wr_combined;
    return !ext_rd_n || !ext_wrl_n || (split && !ext_wrh_n);
  endfunction

  // external device: holds ready low for wait_cfg strobe cycles
  always @(negedge clk) begin
    if (strobing()) begin
      if (wcnt < wait_cfg) begin ext_ready = 1'b0; wcnt++; end
      else ext_ready = 1'b1;
    end else begin
      wcnt = 0;
      ext_ready = 1'b1;
    end
  end

  // monitor
  initial begin
    logic prev_ale = 1'b0;
    int slen = 0;
    logic [19:0] o_x = '0;
    logic [3:0]  o_cs = '0;
    logic [7:0]  o_ad = '0;
    logic        o_aoe = 1'b0, o_bhe = 1'b1;
    logic        o_rd = 1'b1, o_wrl = 1'b1, o_wrh = 1'b1, o_doe = 1'b0;
    logic [15:0] o_d = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (ext_ale) begin
          n_ale++;
          o_x = ext_addr; o_cs = ext_cs_n; o_ad = ext_d_out[7:0];
          o_aoe = ext_d_oe; o_bhe = ext_wrh_n;
          chk("R9", "strobe during ALE", {31'd0, strobing()}, 32'd0);
        end
        if (prev_ale) chk("R9", "strobe after ALE", {31'd0, strobing()}, 32'd1);
        if (strobing()) begin
          if (slen == 0) begin
            o_rd = ext_rd_n; o_wrl = ext_wrl_n; o_wrh = ext_wrh_n;
            o_d = ext_d_out; o_doe = ext_d_oe;
          end
          slen++;
        end
        if (resp_valid) begin
          if (expq.size() == 0) begin
            chk("R10", "unexpected response", 32'd1, 32'd0);
          end else begin
            exp_t e;
            e = expq.pop_front();
            chk("R2", "ext address", {12'd0, o_x}, {12'd0, e.xaddr});
            chk("R5", "cs at ALE", {28'd0, o_cs}, {28'd0, e.cs_n});
            chk("R5", "cs at release", {28'd0, ext_cs_n}, {28'd0, e.cs_n});
            if (e.mux) begin
              chk(e.bus8 ? "R3" : "R4", "mux address", {24'd0, o_ad}, {24'd0, e.aphase});
              chk(e.bus8 ? "R3" : "R4", "mux addr oe", {31'd0, o_aoe}, 32'd1);
            end else begin
              chk("R3", "separate addr-phase oe", {31'd0, o_aoe}, 32'd0);
            end
            chk("R7", "high-byte enable in ALE", {31'd0, o_bhe}, {31'd0, e.bhe_a});
            chk("R8", "rd_n", {31'd0, o_rd}, {31'd0, e.rd_n});
            chk(e.comb ? "R7" : "R6", "wrl_n", {31'd0, o_wrl}, {31'd0, e.wrl_n});
            chk(e.comb ? "R7" : "R6", "wrh_n", {31'd0, o_wrh}, {31'd0, e.wrh_n});
            chk("R10", "strobe length", slen, {24'd0, e.slen});
            if (e.we) begin
              chk("R1", "write data", {16'd0, o_d}, {16'd0, e.wbus});
              chk("R1", "write oe", {31'd0, o_doe}, 32'd1);
            end else begin
              chk("R1", "read data", {16'd0, resp_rdata}, {16'd0, e.rdata});
            end
          end
          slen = 0;
        end
        prev_ale = ext_ale;
      end
    end
  end

  task automatic xfer(input logic we, input logic [19:0] addr,
                      input logic [15:0] wdata, input logic [1:0] be);
    exp_t e;
    logic hi, lo;
    e.we = we; e.mux = cfg_mux; e.bus8 = cfg_bus8;
    e.comb = cfg_bus8 | cfg_wr_combined;
    hi = cfg_bus8 ? addr[0] : be[1];
    lo = cfg_bus8 ? ~addr[0] : be[0];
    e.xaddr  = cfg_bus8 ? addr : {addr[19:1], ~be[0] & be[1]};
    e.cs_n   = ~(4'b0001 << addr[19:18]);
    e.aphase = cfg_bus8 ? addr[7:0] : addr[8:1];
    e.bhe_a  = e.comb ? ~hi : 1'b1;
    e.rd_n   = we;
    e.wrl_n  = we ? (e.comb ? 1'b0 : ~lo) : 1'b1;
    e.wrh_n  = e.comb ? ~hi : (we ? ~hi : 1'b1);
    e.wbus   = cfg_bus8 ? {8'h00, wdata[7:0]} : wdata;
    e.rdata  = cfg_bus8 ? {8'h00, e.xaddr[7:0] ^ 8'h3C} : (e.xaddr[15:0] ^ 16'h5A3C);
    e.slen   = 8'(wait_cfg + 1);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wdata; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    expq.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int ale_before;
    rst = 1'b1; ext_hold_n = 1'b1; ext_ready = 1'b1;
    cfg_bus8 = 1'b0; cfg_mux = 1'b0; cfg_wr_combined = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk("R13", "cs_n", {28'd0, ext_cs_n}, 32'hF);
    chk("R13", "ale", {31'd0, ext_ale}, 32'd0);
    chk("R13", "strobes", {29'd0, ext_rd_n, ext_wrl_n, ext_wrh_n}, 32'd7);
    chk("R13", "hlda_n", {31'd0, ext_hlda_n}, 32'd1);
    chk("R13", "resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R13", "req_ready", {31'd0, req_ready}, 32'd1);

    // 16-bit, separate, split strobes (R6)
    xfer(1'b1, 20'h0_1234, 16'hBEEF, 2'b11);
    xfer(1'b1, 20'h4_5678, 16'h1122, 2'b01);
    xfer(1'b1, 20'h8_9ABC, 16'h3344, 2'b10);
    xfer(1'b0, 20'hC_DEF0, 16'h0000, 2'b11);
    xfer(1'b0, 20'h3_FFFE, 16'h0000, 2'b10);
    drain();
    // wait states (R10)
    wait_cfg = 3;
    xfer(1'b0, 20'h5_0246, 16'h0000, 2'b11);
    xfer(1'b1, 20'h9_1357, 16'hA5A5, 2'b01);
    drain();
    wait_cfg = 0;

    // 16-bit, multiplexed, combined strobe (R4, R7)
    cfg_mux = 1'b1; cfg_wr_combined = 1'b1;
    xfer(1'b1, 20'h2_01FE, 16'h0F0F, 2'b10);
    xfer(1'b0, 20'hE_0300, 16'h0000, 2'b01);
    xfer(1'b0, 20'h7_12A4, 16'h0000, 2'b10);
    xfer(1'b1, 20'hB_7770, 16'h6789, 2'b11);
    drain();

    // 8-bit, multiplexed, split requested but combined forced (R3, R7)
    cfg_bus8 = 1'b1; cfg_wr_combined = 1'b0;
    xfer(1'b1, 20'h1_0081, 16'h12C3, 2'b11);
    xfer(1'b0, 20'hD_4562, 16'h0000, 2'b11);
    xfer(1'b1, 20'h6_00F0, 16'h55AA, 2'b11);
    xfer(1'b0, 20'hA_1FFF, 16'h0000, 2'b11);
    drain();

    // 8-bit, separate (R1, R2)
    cfg_mux = 1'b0;
    xfer(1'b0, 20'hF_8001, 16'h0000, 2'b11);
    xfer(1'b1, 20'h0_0010, 16'h9977, 2'b11);
    drain();
    cfg_bus8 = 1'b0;

    // hold while idle stalls a request (R11)
    ext_hold_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11", "hlda_n in hold", {31'd0, ext_hlda_n}, 32'd0);
    chk("R11", "bus_oe in hold", {31'd0, ext_bus_oe}, 32'd0);
    chk("R11", "d_oe in hold", {31'd0, ext_d_oe}, 32'd0);
    chk("R11", "req_ready in hold", {31'd0, req_ready}, 32'd0);
    ale_before = n_ale;
    fork
      xfer(1'b0, 20'h4_4444, 16'h0000, 2'b11);
      begin
        repeat (6) @(negedge clk);
        chk("R11", "no cycle during hold", n_ale, ale_before);
        chk("R11", "still held", {31'd0, ext_hlda_n}, 32'd0);
        ext_hold_n = 1'b1;
      end
    join
    drain();
    chk("R11", "hlda_n after release", {31'd0, ext_hlda_n}, 32'd1);
    chk("R11", "req_ready after release", {31'd0, req_ready}, 32'd1);

    // hold requested mid-cycle waits for release (R12)
    wait_cfg = 5;
    fork
      xfer(1'b0, 20'h8_0100, 16'h0000, 2'b11);
      begin
        while (ext_rd_n) @(negedge clk);
        ext_hold_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          chk("R12", "no grant mid-cycle", {31'd0, ext_hlda_n}, 32'd1);
        end
      end
    join
    repeat (4) @(negedge clk);
    chk("R12", "grant after cycle", {31'd0, ext_hlda_n}, 32'd0);
    ext_hold_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "hold ends", {31'd0, ext_hlda_n}, 32'd1);
    wait_cfg = 0;
    drain();
    chk("R10", "scoreboard empty", expq.size(), 32'd0);

    report();
    $finish;
  end
endmodule